// File: doc/BRIEF.md
# Deadline-Aware Shared-Bus Arbiter

This block decides which of N masters owns a single shared bus. Every master raises its own request line. The arbiter answers with a one-hot grant and the binary index of the owner. The owner keeps the bus until the transaction-done input is seen, so no policy ever takes the bus away from a master that holds it.

The winner is chosen under one of three policies, picked by a two-bit mode input:

- **Fixed order:** the lowest-numbered requester wins.
- **Programmable:** each master carries a priority value from software, and the highest value wins.
- **Deadline:** each master has a countdown of the cycles it may still wait. The requester closest to its limit wins.

In deadline mode, a master's countdown is loaded from its own maximum-wait input when it makes a new request. The countdown then falls by one for every cycle the master waits without a grant. Whenever keys are equal, the lower index wins.

The mode is read only at the clock edge where a new owner is chosen. That edge is either an idle cycle or the edge that completes the current transaction. A change of mode while the bus is held therefore has no effect until the bus is released.

Top module: `latbus_arbiter`

## Requirements
- R1: At most one grant bit is high at any time. While a grant is held, `gnt_idx` equals the position of the set bit; with no grant, `gnt_idx` is 0.
- R2: Grants are non-preemptive. Once issued, a grant stays unchanged until a cycle with `xfer_done` high. At that edge a new owner is chosen among the current requesters, and the finishing master may be chosen again.
- R3: Only masters with their request bit high at the arbitration edge are considered. If none is requesting, no grant bit is set in the following cycle.
- R4: With `mode` 2'b00 or 2'b11 (fixed order), the requester with the lowest index is granted.
- R5: With `mode` 2'b01 (programmable), the requester with the largest value in its `PRIO_W`-bit field of `prio_vec` (master i at bits i*PRIO_W upward) is granted. Equal values go to the lower index.
- R6: With `mode` 2'b10 (deadline), the requester with the smallest remaining count is granted. A master's count is its `LAT_W`-bit field of `max_wait_vec` (master i at bits i*LAT_W upward) on the first edge its request is seen.
- R7: In deadline mode, a waiting, ungranted requester's count drops by one on every clock edge after it was loaded. The count holds at zero instead of wrapping.
- R8: In deadline mode, equal remaining counts go to the lower index.
- R9: A granted master's count is frozen while it holds the bus. When its transaction completes while it still requests, it counts as a new request and its count is reloaded from `max_wait_vec`. A master that drops its request loses its count.
- R10: `mode` is used only at an arbitration edge. Changes while a grant is held do not alter the grant.
- R11: During and right after reset, `gnt` is all zero and `gnt_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-master request lines |
| max_wait_vec | input | N*LAT_W | Per-master maximum allowed wait, packed |
| prio_vec | input | N*PRIO_W | Per-master programmable priority, packed |
| mode | input | 2 | Policy select: 00/11 fixed, 01 programmable, 10 deadline |
| xfer_done | input | 1 | Current transaction completes this cycle |
| gnt | output | N | One-hot grant |
| gnt_idx | output | IDX_W | Index of the granted master |

## Verification
The bench builds the arbiter with four masters, four-bit wait counts and two-bit priorities. The four-bit counts are small enough that a master's countdown reaches zero within one held grant, which brings saturation, equal counts at zero and the index tie-break into a short run. Two-bit priorities make equal programmable priorities common under random stimulus. A random phase changes the mode, the wait limits and the priorities while grants are held, so policy changes at arbitration edges and back-to-back regrants of the finishing master are covered alongside the directed cases.

// File: rtl/latbus_arb_pkg.sv
package latbus_arb_pkg;

   typedef enum logic [1:0] {
      POL_FIXED    = 2'b00,
      POL_PROG     = 2'b01,
      POL_DEADLINE = 2'b10,
      POL_FIXED_B  = 2'b11
   } arb_policy_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/latbus_wait_cnt.sv
module latbus_wait_cnt #(
   parameter int unsigned LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             owner,
   input  logic             finish,
   input  logic [LAT_W-1:0] max_wait,
   output logic [LAT_W-1:0] eff_wait
);

   logic             armed_q;
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (!req) begin
         armed_q <= 1'b0;
      end else if (!armed_q || finish) begin
         armed_q <= 1'b1;
         cnt_q   <= max_wait;
      end else if (!owner) begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   // a fresh or re-issued request is compared on its full allowance
   assign eff_wait = (armed_q && !finish) ? cnt_q : max_wait;

endmodule

// File: rtl/latbus_key_gen.sv
module latbus_key_gen
   import latbus_arb_pkg::*;
#(
   parameter int unsigned LAT_W  = 4,
   parameter int unsigned PRIO_W = 2,
   parameter int unsigned KEY_W  = 4
) (
   input  arb_policy_e       policy,
   input  logic [PRIO_W-1:0] prio,
   input  logic [LAT_W-1:0]  eff_wait,
   output logic [KEY_W-1:0]  key
);

   logic [PRIO_W-1:0] prio_inv;
   assign prio_inv = ~prio;

   // smaller key wins in every policy
   always_comb begin
      unique case (policy)
         POL_PROG:     key = KEY_W'(prio_inv);
         POL_DEADLINE: key = KEY_W'(eff_wait);
         default:      key = '0;
      endcase
   end

endmodule

// File: rtl/latbus_pick.sv
module latbus_pick #(
   parameter int unsigned N     = 4,
   parameter int unsigned KEY_W = 4
) (
   input  logic [N-1:0]            req,
   input  logic [N-1:0][KEY_W-1:0] keys,
   output logic [N-1:0]            win,
   output logic                    any
);

   logic [KEY_W-1:0] best;

   // strict compare in ascending index order keeps ties at the lower index
   always_comb begin
      any  = 1'b0;
      best = '0;
      win  = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req[i] && (!any || keys[i] < best)) begin
            any    = 1'b1;
            best   = keys[i];
            win    = '0;
            win[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/latbus_arbiter.sv
module latbus_arbiter
   import latbus_arb_pkg::*;
#(
   parameter int unsigned N      = 4,
   parameter int unsigned LAT_W  = 4,
   parameter int unsigned PRIO_W = 2,
   localparam int unsigned IDX_W = $clog2(N),
   localparam int unsigned KEY_W = max2(LAT_W, PRIO_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        req,
   input  logic [N*LAT_W-1:0]  max_wait_vec,
   input  logic [N*PRIO_W-1:0] prio_vec,
   input  logic [1:0]          mode,
   input  logic                xfer_done,
   output logic [N-1:0]        gnt,
   output logic [IDX_W-1:0]    gnt_idx
);

   if (N < 2) begin : g_bad_n
      $error("latbus_arbiter: N must be at least 2");
   end
   if (LAT_W < 1 || LAT_W > 16) begin : g_bad_lat
      $error("latbus_arbiter: LAT_W must be 1..16");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("latbus_arbiter: PRIO_W must be 1..8");
   end

   arb_policy_e             policy;
   logic [N-1:0]            gnt_q;
   logic [IDX_W-1:0]        idx_q;
   logic [N-1:0]            finish;
   logic [N-1:0][KEY_W-1:0] keys;
   logic [N-1:0]            win;
   logic                    any_win;
   logic                    busy;
   logic                    arb_edge;
   logic [IDX_W-1:0]        win_idx;

   assign policy   = arb_policy_e'(mode);
   assign busy     = |gnt_q;
   assign arb_edge = !busy || xfer_done;
   assign finish   = gnt_q & {N{xfer_done}};

   for (genvar i = 0; i < int'(N); i++) begin : g_ch
      logic [LAT_W-1:0] eff;

      latbus_wait_cnt #(.LAT_W(LAT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (req[i]),
         .owner    (gnt_q[i]),
         .finish   (finish[i]),
         .max_wait (max_wait_vec[i*LAT_W +: LAT_W]),
         .eff_wait (eff)
      );

      latbus_key_gen #(.LAT_W(LAT_W), .PRIO_W(PRIO_W), .KEY_W(KEY_W)) u_key (
         .policy   (policy),
         .prio     (prio_vec[i*PRIO_W +: PRIO_W]),
         .eff_wait (eff),
         .key      (keys[i])
      );
   end

   latbus_pick #(.N(N), .KEY_W(KEY_W)) u_pick (
      .req  (req),
      .keys (keys),
      .win  (win),
      .any  (any_win)
   );

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (win[i]) win_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q <= '0;
         idx_q <= '0;
      end else if (arb_edge) begin
         gnt_q <= any_win ? win : '0;
         idx_q <= any_win ? win_idx : '0;
      end
   end

   assign gnt     = gnt_q;
   assign gnt_idx = idx_q;

endmodule

// File: rtl/latbus_arbiter_chk.sv
module latbus_arbiter_chk #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     req,
   input logic [1:0]       mode,
   input logic             xfer_done,
   input logic [N-1:0]     gnt,
   input logic [IDX_W-1:0] gnt_idx
);

   logic arb_edge;
   assign arb_edge = (gnt == '0) || xfer_done;

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_idx_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> gnt[gnt_idx]);

   assert_idx_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0) |-> (gnt_idx == '0));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt != '0) && !xfer_done) |=> $stable(gnt));

   assert_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_edge && req == '0) |=> (gnt == '0));

   assert_granted_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_edge && req != '0) |=> ((gnt & $past(req)) != '0));

   assert_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_edge && (mode == 2'b00 || mode == 2'b11) && req != '0)
      |=> (gnt == $past(req & (~req + 1'b1))));

endmodule

bind latbus_arbiter latbus_arbiter_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .mode      (mode),
   .xfer_done (xfer_done),
   .gnt       (gnt),
   .gnt_idx   (gnt_idx)
);

// File: tb/tb_latbus_arbiter.sv
`timescale 1ns/1ps
module tb_latbus_arbiter;

   localparam int N  = 4;
   localparam int LW = 4;
   localparam int PW = 2;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N*LW-1:0] lat_v = '0;
   logic [N*PW-1:0] prio_v = '0;
   logic [1:0]    mode = 2'b00;
   logic          done = 1'b0;
   logic [N-1:0]  gnt;
   logic [IW-1:0] gnt_idx;

   int checks = 0;
   int errors = 0;
   string tag = "R11";
   bit finished = 0;

   always #2.5 clk = ~clk;

   latbus_arbiter #(.N(N), .LAT_W(LW), .PRIO_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .max_wait_vec(lat_v),
      .prio_vec(prio_v), .mode(mode), .xfer_done(done),
      .gnt(gnt), .gnt_idx(gnt_idx));

   // behavioural reference
   int m_own = -1;
   bit m_armed [N];
   int m_cnt [N];

   function automatic int lat_of(int i);
      return int'(lat_v[i*LW +: LW]);
   endfunction
   function automatic int prio_of(int i);
      return int'(prio_v[i*PW +: PW]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_own = -1;
         for (int i = 0; i < N; i++) begin m_armed[i] = 0; m_cnt[i] = 0; end
      end else begin
         int win;
         int best;
         bit arb;
         arb = (m_own < 0) || done;
         win = -1; best = 0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) begin
               int k;
               if (mode == 2'b01) k = -prio_of(i);
               else if (mode == 2'b10)
                  k = (m_armed[i] && !(m_own == i && done)) ? m_cnt[i] : lat_of(i);
               else k = 0;
               if (win < 0 || k < best) begin win = i; best = k; end
            end
         end
         for (int i = 0; i < N; i++) begin
            if (!req[i]) m_armed[i] = 0;
            else if (!m_armed[i] || (m_own == i && done)) begin
               m_armed[i] = 1; m_cnt[i] = lat_of(i);
            end else if (m_own != i && m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
         end
         if (arb) m_own = win;
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         logic [N-1:0] eg;
         int ei;
         eg = (m_own >= 0) ? (N'(1) << m_own) : '0;
         ei = (m_own >= 0) ? m_own : 0;
         checks++;
         if (gnt !== eg || int'(gnt_idx) != ei) begin
            errors++;
            $display("FAIL %s gnt act %b exp %b idx act %0d exp %0d t=%0t",
                     tag, gnt, eg, gnt_idx, ei, $time);
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic set_lat(int i, int v);
      lat_v[i*LW +: LW] = LW'(v);
   endtask
   task automatic set_prio(int i, int v);
      prio_v[i*PW +: PW] = PW'(v);
   endtask
   task automatic pulse_done();
      done = 1'b1; cyc(1); done = 1'b0;
   endtask

   initial begin
      // R11: reset state
      tag = "R11";
      cyc(3);
      checks++;
      if (gnt !== '0 || gnt_idx !== '0) begin
         errors++;
         $display("FAIL R11 gnt act %b exp 0 idx act %0d exp 0", gnt, gnt_idx);
      end
      rst_n = 1'b1;
      cyc(1);

      // R3: nothing requested, nothing granted
      tag = "R3"; cyc(4);
      req = 4'b0100; cyc(2); req = 4'b0000; pulse_done(); cyc(3);

      // R4: fixed order, both encodings
      tag = "R4"; mode = 2'b00;
      req = 4'b1110; cyc(3); pulse_done(); cyc(2);
      req = 4'b1100; pulse_done(); cyc(2);
      mode = 2'b11; req = 4'b1011; pulse_done(); cyc(2);
      req = 4'b0000; pulse_done(); cyc(2);

      // R5: programmable priority with ties
      tag = "R5"; mode = 2'b01;
      set_prio(0, 1); set_prio(1, 3); set_prio(2, 2); set_prio(3, 3);
      req = 4'b1111; cyc(2); pulse_done(); cyc(1);
      req = 4'b0101; pulse_done(); cyc(2);
      set_prio(0, 2); pulse_done(); cyc(2);
      req = 4'b0000; pulse_done(); cyc(2);

      // R6 / R7 / R8: deadline counts, saturation, ties
      tag = "R6"; mode = 2'b10;
      set_lat(0, 15); set_lat(1, 9); set_lat(2, 4); set_lat(3, 6);
      req = 4'b1011; cyc(2); pulse_done(); cyc(2);
      tag = "R7"; req = 4'b1111; cyc(20); pulse_done(); cyc(2);
      tag = "R8"; pulse_done(); cyc(2); pulse_done(); cyc(2); pulse_done(); cyc(2);
      req = 4'b0000; pulse_done(); cyc(2);
      set_lat(0, 3); set_lat(1, 3); set_lat(2, 3); set_lat(3, 3);
      req = 4'b0110; cyc(1); req = 4'b1110; cyc(1); pulse_done(); cyc(1);
      pulse_done(); cyc(1); pulse_done(); cyc(1);

      // R9: owner frozen, regrant reloads full allowance
      tag = "R9"; req = 4'b0000; pulse_done(); cyc(1);
      set_lat(0, 1); set_lat(1, 8);
      req = 4'b0011; cyc(12); pulse_done(); cyc(3); pulse_done(); cyc(2);
      req = 4'b0010; cyc(1); req = 4'b0011; pulse_done(); cyc(2);
      req = 4'b0000; pulse_done(); cyc(2);

      // R10: mode changes while held do nothing until release
      tag = "R10"; mode = 2'b00; req = 4'b1001; cyc(2);
      mode = 2'b01; set_prio(3, 3); set_prio(0, 0); cyc(4);
      mode = 2'b10; cyc(3); mode = 2'b01; pulse_done(); cyc(3);
      req = 4'b0000; pulse_done(); cyc(2);

      // R2 / R1: random traffic, all policies, back-to-back regrants
      tag = "R2";
      for (int n = 0; n < 3000; n++) begin
         req  = N'($urandom);
         done = ($urandom % 3) == 0;
         if ($urandom % 16 == 0) mode = 2'($urandom);
         if ($urandom % 20 == 0) set_lat($urandom % N, $urandom % 16);
         if ($urandom % 20 == 0) set_prio($urandom % N, $urandom % 4);
         cyc(1);
      end
      done = 1'b0; req = '0; cyc(2);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired in %s", tag);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule